// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the cross-port interrupt flags for a two-port memory. The two highest word addresses of the memory act as mailboxes. A port writes a message into its partner's mailbox, and that write raises an active-low interrupt toward the partner. The partner reads the mailbox to fetch the message, and that read clears the flag. The message words are ordinary memory contents and are not held here. This logic only watches the access strobes and addresses of both ports.

The left port's mailbox is address `DEPTH-2`. The right port's mailbox is address `DEPTH-1`. With the default depth of 16384 words these are 0x3FFE and 0x3FFF. A depth of 8192 gives 0x1FFE/0x1FFF, and 4096 gives 0xFFE/0xFFF.

All access strobes are active-high and are sampled on each rising clock edge. A cycle in which a port's select is high counts as one access by that port. Each flag is a register, so its output changes one clock edge after the triggering access. Driving `mailboxEn` low turns the feature off: the top two words then behave as plain memory and both flags stay inactive.

Top module: `mbox_irq`

## Requirements
- R1: While `rstN` is low, and after it is released, `leftIntN` and `rightIntN` are both 1 (inactive) until a setting access occurs.
- R2: `leftIntN` goes to 0 after the clock edge at which `mailboxEn`, `rightSel` and `rightWrEn` are all 1 and `rightAddr` equals `DEPTH-2`.
- R3: `rightIntN` goes to 0 after the clock edge at which `mailboxEn`, `leftSel` and `leftWrEn` are all 1 and `leftAddr` equals `DEPTH-1`.
- R4: A setting access needs both the select and the write enable at 1. A select with the write enable at 0, or a write enable with the select at 0, sets no flag.
- R5: `leftIntN` returns to 1 after an edge at which `leftSel` and `leftRdEn` are 1 and `leftAddr` equals `DEPTH-2`. The value of `leftWrEn` has no effect on this clear.
- R6: `rightIntN` returns to 1 after an edge at which `rightSel` and `rightRdEn` are 1 and `rightAddr` equals `DEPTH-1`. The value of `rightWrEn` has no effect on this clear.
- R7: When a set and a clear of the same flag occur at the same edge, the flag ends up set (0).
- R8: While `mailboxEn` is 0, no flag is set, and both outputs are 1 after the next edge.
- R9: A port writing its own mailbox, or any address other than its partner's mailbox, does not change the flag toward the partner.
- R10: With no set or clear at an edge, each flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| mailboxEn | input | 1 | Enables the mailbox interrupt feature |
| leftSel | input | 1 | Left port select, active high |
| leftWrEn | input | 1 | Left port write enable, active high |
| leftRdEn | input | 1 | Left port output enable, active high |
| leftAddr | input | AW | Left port word address |
| rightSel | input | 1 | Right port select, active high |
| rightWrEn | input | 1 | Right port write enable, active high |
| rightRdEn | input | 1 | Right port output enable, active high |
| rightAddr | input | AW | Right port word address |
| leftIntN | output | 1 | Interrupt toward the left port, active low |
| rightIntN | output | 1 | Interrupt toward the right port, active low |

## Verification
Each flag is a single register, so a wrong decode or a wrong priority shows up on an interrupt pin at the very next edge. A missed set leaves the pin high when it should be low. A spurious clear releases it too early. A stuck flag goes on disagreeing for every later cycle until the next set or clear corrects it.

The bench uses a 16-word memory. It sweeps every address and strobe combination of both ports, with the feature both on and off, and compares the two pins against an arithmetic model after every edge. Directed cases cover the set-over-clear priority and the write-enable-ignored clear.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  // Index of each flag inside the datapath array
  localparam int FlagLeft  = 0;
  localparam int FlagRight = 1;
  localparam int NumFlags  = 2;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic [NumFlags-1:0] setFlag;
    logic [NumFlags-1:0] clrFlag;
    logic                flush;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int DEPTH = 16384,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          mailboxEn,
  input  logic          leftSel,
  input  logic          leftWrEn,
  input  logic          leftRdEn,
  input  logic [AW-1:0] leftAddr,
  input  logic          rightSel,
  input  logic          rightWrEn,
  input  logic          rightRdEn,
  input  logic [AW-1:0] rightAddr,
  output mboxStrobe_t   strobe
);
  localparam logic [AW-1:0] LeftBox  = AW'(DEPTH - 2);
  localparam logic [AW-1:0] RightBox = AW'(DEPTH - 1);

  logic leftHitsLeftBox, leftHitsRightBox;
  logic rightHitsLeftBox, rightHitsRightBox;

  always_comb begin
    leftHitsLeftBox   = leftSel  && (leftAddr  == LeftBox);
    leftHitsRightBox  = leftSel  && (leftAddr  == RightBox);
    rightHitsLeftBox  = rightSel && (rightAddr == LeftBox);
    rightHitsRightBox = rightSel && (rightAddr == RightBox);

    strobe = '0;
    strobe.flush = !mailboxEn;
    // A write by the partner sets the flag
    strobe.setFlag[FlagLeft]  = mailboxEn && rightHitsLeftBox && rightWrEn;
    strobe.setFlag[FlagRight] = mailboxEn && leftHitsRightBox && leftWrEn;
    // An output-enabled access by the owner clears it; write enable ignored
    strobe.clrFlag[FlagLeft]  = leftHitsLeftBox  && leftRdEn;
    strobe.clrFlag[FlagRight] = rightHitsRightBox && rightRdEn;
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mboxStrobe_t strobe,
  output logic        leftIntN,
  output logic        rightIntN
);
  logic [NumFlags-1:0] pending;

  for (genvar g = 0; g < NumFlags; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN || strobe.flush)     pending[g] <= 1'b0;
      else if (strobe.setFlag[g])    pending[g] <= 1'b1;  // set wins over clear
      else if (strobe.clrFlag[g])    pending[g] <= 1'b0;
    end
  end

  assign leftIntN  = !pending[FlagLeft];
  assign rightIntN = !pending[FlagRight];
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_irq_pkg::*;
#(
  parameter int DEPTH = 16384,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mailboxEn,
  input  logic          leftSel,
  input  logic          leftWrEn,
  input  logic          leftRdEn,
  input  logic [AW-1:0] leftAddr,
  input  logic          rightSel,
  input  logic          rightWrEn,
  input  logic          rightRdEn,
  input  logic [AW-1:0] rightAddr,
  output logic          leftIntN,
  output logic          rightIntN
);
  mboxStrobe_t strobe;

  mbox_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .mailboxEn(mailboxEn),
    .leftSel(leftSel), .leftWrEn(leftWrEn), .leftRdEn(leftRdEn), .leftAddr(leftAddr),
    .rightSel(rightSel), .rightWrEn(rightWrEn), .rightRdEn(rightRdEn), .rightAddr(rightAddr),
    .strobe(strobe)
  );

  mbox_flags u_flags (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .leftIntN(leftIntN), .rightIntN(rightIntN)
  );
endmodule

// File: rtl/mbox_irq_checker.sv
module mbox_irq_checker #(
  parameter int DEPTH = 16384,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rstN,
  input logic          mailboxEn,
  input logic          leftSel,
  input logic          leftWrEn,
  input logic          leftRdEn,
  input logic [AW-1:0] leftAddr,
  input logic          rightSel,
  input logic          rightWrEn,
  input logic          rightRdEn,
  input logic [AW-1:0] rightAddr,
  input logic          leftIntN,
  input logic          rightIntN
);
  localparam logic [AW-1:0] LBox = AW'(DEPTH - 2);
  localparam logic [AW-1:0] RBox = AW'(DEPTH - 1);

  logic setL, setR, clrL, clrR;
  assign setL = mailboxEn && rightSel && rightWrEn && rightAddr == LBox;
  assign setR = mailboxEn && leftSel && leftWrEn && leftAddr == RBox;
  assign clrL = leftSel && leftRdEn && leftAddr == LBox;
  assign clrR = rightSel && rightRdEn && rightAddr == RBox;

  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> leftIntN && rightIntN);
  p_set_left_r2: assert property (@(posedge clk) disable iff (!rstN) setL |=> !leftIntN);
  p_set_right_r3: assert property (@(posedge clk) disable iff (!rstN) setR |=> !rightIntN);
  p_clear_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrL && !setL) |=> leftIntN);
  p_clear_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrR && !setR) |=> rightIntN);
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    !mailboxEn |=> leftIntN && rightIntN);
  p_hold_left_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mailboxEn && !setL && !clrL) |=> $stable(leftIntN));
  p_hold_right_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mailboxEn && !setR && !clrR) |=> $stable(rightIntN));
endmodule

bind mbox_irq mbox_irq_checker #(.DEPTH(DEPTH), .AW(AW)) u_checker (.*);

// File: tb/mbox_irq_tb.sv
module mbox_irq_tb;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LBox = AW'(DEPTH - 2);
  localparam logic [AW-1:0] RBox = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic lSel = 0, lWr = 0, lRd = 0, rSel = 0, rWr = 0, rRd = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic leftIntN, rightIntN;
  logic expL = 1'b1, expR = 1'b1;  // expected pin levels
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_irq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .mailboxEn(en),
    .leftSel(lSel), .leftWrEn(lWr), .leftRdEn(lRd), .leftAddr(lAddr),
    .rightSel(rSel), .rightWrEn(rWr), .rightRdEn(rRd), .rightAddr(rAddr),
    .leftIntN(leftIntN), .rightIntN(rightIntN)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one access pair, clock it, update the model, sample at the falling edge
  task automatic cyc(input logic e, input logic [2:0] lc, input logic [AW-1:0] la,
                     input logic [2:0] rc, input logic [AW-1:0] ra);
    logic sL, sR, cL, cR;
    en = e; {lSel, lWr, lRd} = lc; lAddr = la; {rSel, rWr, rRd} = rc; rAddr = ra;
    sL = e && rc[2] && rc[1] && ra == LBox;
    sR = e && lc[2] && lc[1] && la == RBox;
    cL = lc[2] && lc[0] && la == LBox;
    cR = rc[2] && rc[0] && ra == RBox;
    @(posedge clk);
    if (!e) begin expL = 1; expR = 1; end
    else begin
      if (sL) expL = 0; else if (cL) expL = 1;
      if (sR) expR = 0; else if (cR) expR = 1;
    end
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 left", leftIntN, 1'b1);
    check("R1 right", rightIntN, 1'b1);
    rstN = 1;
    cyc(1, 3'b000, 0, 3'b000, 0);
    check("R1 left idle", leftIntN, 1'b1);
    // Partial write strobes on the right do not set
    cyc(1, 3'b000, 0, 3'b100, LBox);
    check("R4 sel only", leftIntN, 1'b1);
    cyc(1, 3'b000, 0, 3'b010, LBox);
    check("R4 wr only", leftIntN, 1'b1);
    cyc(1, 3'b000, 0, 3'b110, LBox);
    check("R2 set", leftIntN, 1'b0);
    cyc(1, 3'b000, 0, 3'b000, 0);
    check("R10 hold", leftIntN, 1'b0);
    // Clear with write enable also high
    cyc(1, 3'b111, LBox, 3'b000, 0);
    check("R5 clear wr ignored", leftIntN, 1'b1);
    cyc(1, 3'b110, RBox, 3'b000, 0);
    check("R3 set", rightIntN, 1'b0);
    cyc(1, 3'b000, 0, 3'b101, RBox);
    check("R6 clear", rightIntN, 1'b1);
    // Set and clear of left flag at the same edge
    cyc(1, 3'b101, LBox, 3'b110, LBox);
    check("R7 set wins", leftIntN, 1'b0);
    // Right writes its own mailbox: no flag toward itself
    cyc(1, 3'b000, 0, 3'b110, RBox);
    check("R9 own box", rightIntN, 1'b1);
    cyc(0, 3'b000, 0, 3'b000, 0);
    check("R8 flush", leftIntN, 1'b1);
    cyc(0, 3'b110, RBox, 3'b110, LBox);
    check("R8 no set left", leftIntN, 1'b1);
    check("R8 no set right", rightIntN, 1'b1);
    // Exhaustive sweep of one-cycle access pairs, feature on and off
    for (int e = 1; e >= 0; e--)
      for (int la = 0; la < DEPTH; la++)
        for (int lc = 0; lc < 8; lc++)
          for (int ra = 0; ra < DEPTH; ra++)
            for (int rc = 0; rc < 8; rc++) begin
              cyc(e[0], lc[2:0], AW'(la), rc[2:0], AW'(ra));
              check("R2/R5/R7/R8/R9/R10 left sweep", leftIntN, expL);
              check("R3/R6/R7/R8/R9/R10 right sweep", rightIntN, expR);
            end
    finish_up();
  end
endmodule